// File: doc/BRIEF.md
# Three-subframe TDM bus frame transceiver

This block sits on a serial time-division bus whose frame repeats at 8 kHz and is 96 bits long, built from three 32-bit subframes. A one-cycle frame sync marks the first bit of each frame. On the send side, the block takes a set of parallel channel values, copies them into a shadow copy when a frame begins, and shifts that copy out serially. On the receive side, it collects the serial input into a frame buffer. When the last bit of the frame arrives, it publishes every channel at once and raises a one-cycle strobe.

The first subframe carries two 8-bit bearer channels, a monitor byte, a 2-bit signalling channel, a 4-bit command/indicate code and a receive/transmit handshake bit pair. The second subframe carries two 8-bit intercommunication channels, a second monitor byte, a 6-bit command/indicate code and a second handshake pair. The third subframe passes through as 32 opaque bits. All fields travel most significant bit first, except the signalling channel, which travels least significant bit first.

The serial clock drives the block directly. Input bits are taken on its rising edge and output bits change on its falling edge. A sync that arrives anywhere other than the expected frame start re-aligns the frame and sets a sticky error flag.

Top module: `iom_frame_xcvr`

## Requirements
- R1: A rising edge with `fsync` high makes that edge's bit frame position 0. Each later rising edge without `fsync` advances the position by one. After position 95 the position wraps to 0 without needing a sync.
- R2: Received fields take these frame positions, MSB first. In subframe 0: B1 0-7, B2 8-15, monitor 0 16-23, C/I 26-29, MR 30, MX 31. In subframe 1: IC1 32-39, IC2 40-47, monitor 1 48-55, C/I 56-61, MR 62, MX 63.
- R3: The 2-bit signalling channel occupies positions 24 and 25 in both directions. Its bit 0 is at position 24 and its bit 1 is at position 25.
- R4: The bit for frame position p is driven on `sdout` at the falling edge that follows the rising edge of position p-1, using the R2/R3/R9 layout. `sdout` then holds until the next falling edge.
- R5: All transmit inputs are captured at the falling edge where the next position is 0. Changes to them during a frame do not appear on `sdout` until the following frame.
- R6: All receive outputs update together at the rising edge of position 95. `rx_valid` is high for exactly the following cycle, and the receive outputs hold their values at all other times.
- R7: A sync at any position other than the expected frame start sets `frame_err` and re-aligns the count to that edge. `frame_err` then stays high until reset, and it never rises without such a sync.
- R8: While `rst_n` is low, `sdout`, `rx_valid`, `frame_err` and all receive outputs are 0.
- R9: Frame positions 64-95 carry `tx_sub2`/`rx_sub2` as one 32-bit word, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, marks position 0 |
| sdin | input | 1 | Serial data in, sampled on rising edge |
| sdout | output | 1 | Serial data out, changes on falling edge |
| tx_b1 | input | 8 | Bearer channel 1 to send |
| tx_b2 | input | 8 | Bearer channel 2 to send |
| tx_mon0 | input | 8 | Monitor byte, subframe 0 |
| tx_d | input | 2 | Signalling channel bits |
| tx_ci0 | input | 4 | Command/indicate code, subframe 0 |
| tx_mr0 | input | 1 | Receive handshake bit, subframe 0 |
| tx_mx0 | input | 1 | Transmit handshake bit, subframe 0 |
| tx_ic1 | input | 8 | Intercommunication channel 1 |
| tx_ic2 | input | 8 | Intercommunication channel 2 |
| tx_mon1 | input | 8 | Monitor byte, subframe 1 |
| tx_ci1 | input | 6 | Command/indicate code, subframe 1 |
| tx_mr1 | input | 1 | Receive handshake bit, subframe 1 |
| tx_mx1 | input | 1 | Transmit handshake bit, subframe 1 |
| tx_sub2 | input | 32 | Opaque third subframe |
| rx_b1 | output | 8 | Received bearer channel 1 |
| rx_b2 | output | 8 | Received bearer channel 2 |
| rx_mon0 | output | 8 | Received monitor byte, subframe 0 |
| rx_d | output | 2 | Received signalling bits |
| rx_ci0 | output | 4 | Received command/indicate, subframe 0 |
| rx_mr0 | output | 1 | Received handshake bit MR, subframe 0 |
| rx_mx0 | output | 1 | Received handshake bit MX, subframe 0 |
| rx_ic1 | output | 8 | Received intercommunication channel 1 |
| rx_ic2 | output | 8 | Received intercommunication channel 2 |
| rx_mon1 | output | 8 | Received monitor byte, subframe 1 |
| rx_ci1 | output | 6 | Received command/indicate, subframe 1 |
| rx_mr1 | output | 1 | Received handshake bit MR, subframe 1 |
| rx_mx1 | output | 1 | Received handshake bit MX, subframe 1 |
| rx_sub2 | output | 32 | Received opaque third subframe |
| rx_valid | output | 1 | One-cycle strobe after a complete frame |
| frame_err | output | 1 | Sticky misaligned-sync flag |

## Verification
On every cycle, the assertions check the following. The receive strobe lasts one cycle and comes only after position 95. Receive outputs hold between strobes. The error flag rises exactly on a misplaced sync and never falls. The reset state holds while reset is low. The bit-level layout, the least-significant-first signalling bits, the shadow capture of transmit inputs and the wrap without sync need data-dependent comparison. Only the bench's scenarios show those, through its per-cycle reference model and its loopback and mid-frame-update runs.

// File: rtl/iom_xcvr_pkg.sv
package iom_xcvr_pkg;

  localparam int SUB_W    = 32;
  localparam int NUM_SUB  = 3;
  localparam int FRAME_W  = SUB_W * NUM_SUB;
  localparam int POS_W    = $clog2(FRAME_W);
  localparam int OCT_W    = 8;
  localparam int SIG_W    = 2;
  localparam int CI0_W    = 4;
  localparam int CI1_W    = 6;
  localparam int SUB2_W   = SUB_W;

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);

  typedef struct packed {
    logic [OCT_W-1:0]  b1;
    logic [OCT_W-1:0]  b2;
    logic [OCT_W-1:0]  mon0;
    logic [SIG_W-1:0]  sig;
    logic [CI0_W-1:0]  ci0;
    logic              mr0;
    logic              mx0;
    logic [OCT_W-1:0]  ic1;
    logic [OCT_W-1:0]  ic2;
    logic [OCT_W-1:0]  mon1;
    logic [CI1_W-1:0]  ci1;
    logic              mr1;
    logic              mx1;
    logic [SUB2_W-1:0] sub2;
  } chan_t;

  // Reverse the signalling field; all others keep MSB-first order.
  function automatic logic [SIG_W-1:0] flip_sig(input logic [SIG_W-1:0] v);
    logic [SIG_W-1:0] r;
    for (int i = 0; i < SIG_W; i++) r[i] = v[SIG_W-1-i];
    return r;
  endfunction

  // Wire vector: index FRAME_W-1-p holds the bit at frame position p.
  function automatic logic [FRAME_W-1:0] chan_to_wire(input chan_t c);
    chan_t t;
    t     = c;
    t.sig = flip_sig(c.sig);
    return t;
  endfunction

  function automatic chan_t wire_to_chan(input logic [FRAME_W-1:0] w);
    chan_t t;
    t     = w;
    t.sig = flip_sig(t.sig);
    return t;
  endfunction

endpackage

// File: rtl/iom_pos_counter.sv
module iom_pos_counter
  import iom_xcvr_pkg::*;
(
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic [POS_W-1:0] cur_pos,
  output logic [POS_W-1:0] next_pos_q,
  output logic             frame_err
);

  logic [POS_W-1:0] next_pos_d;
  logic             err_q;
  logic             err_d;
  logic             slip;

  always_comb begin
    slip       = fsync && (next_pos_q != '0);
    cur_pos    = fsync ? '0 : next_pos_q;
    next_pos_d = (cur_pos == LAST_POS) ? '0 : cur_pos + 1'b1;
    err_d      = err_q | slip;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      next_pos_q <= '0;
      err_q      <= 1'b0;
    end else begin
      next_pos_q <= next_pos_d;
      err_q      <= err_d;
    end
  end

  assign frame_err = err_q;

endmodule

// File: rtl/iom_rx_deframer.sv
module iom_rx_deframer
  import iom_xcvr_pkg::*;
(
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             sdin,
  input  logic [POS_W-1:0] cur_pos,
  output chan_t            rx_ch,
  output logic             rx_valid
);

  logic [FRAME_W-1:1] cap_w;
  logic               frame_end;
  chan_t              rx_ch_d;
  chan_t              rx_ch_q;
  logic               valid_d;
  logic               valid_q;

  // One capture cell per frame position; the final position bypasses storage.
  for (genvar g = 1; g < FRAME_W; g++) begin : g_cell
    logic cell_q;
    logic cell_d;
    logic cell_en;

    always_comb begin
      cell_en = (cur_pos == POS_W'(FRAME_W - 1 - g));
      cell_d  = cell_en ? sdin : cell_q;
    end

    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) cell_q <= 1'b0;
      else        cell_q <= cell_d;
    end

    assign cap_w[g] = cell_q;
  end

  always_comb begin
    frame_end = (cur_pos == LAST_POS);
    valid_d   = frame_end;
    rx_ch_d   = frame_end ? wire_to_chan({cap_w, sdin}) : rx_ch_q;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ch_q <= '0;
      valid_q <= 1'b0;
    end else begin
      rx_ch_q <= rx_ch_d;
      valid_q <= valid_d;
    end
  end

  assign rx_ch    = rx_ch_q;
  assign rx_valid = valid_q;

endmodule

// File: rtl/iom_tx_framer.sv
module iom_tx_framer
  import iom_xcvr_pkg::*;
(
  input  logic             sclk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] next_pos_q,
  input  chan_t            tx_ch,
  output logic             sdout
);

  logic [FRAME_W-1:0] live_w;
  logic [FRAME_W-1:0] shadow_d;
  logic [FRAME_W-1:0] shadow_q;
  logic               frame_start;
  logic [POS_W-1:0]   bit_idx;
  logic               sd_d;
  logic               sd_q;

  always_comb begin
    live_w      = chan_to_wire(tx_ch);
    frame_start = (next_pos_q == '0);
    shadow_d    = frame_start ? live_w : shadow_q;
    bit_idx     = LAST_POS - next_pos_q;
    sd_d        = shadow_d[bit_idx];
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      sd_q     <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      sd_q     <= sd_d;
    end
  end

  assign sdout = sd_q;

endmodule

// File: rtl/iom_frame_xcvr.sv
module iom_frame_xcvr
  import iom_xcvr_pkg::*;
(
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              sdin,
  output logic              sdout,
  input  logic [OCT_W-1:0]  tx_b1,
  input  logic [OCT_W-1:0]  tx_b2,
  input  logic [OCT_W-1:0]  tx_mon0,
  input  logic [SIG_W-1:0]  tx_d,
  input  logic [CI0_W-1:0]  tx_ci0,
  input  logic              tx_mr0,
  input  logic              tx_mx0,
  input  logic [OCT_W-1:0]  tx_ic1,
  input  logic [OCT_W-1:0]  tx_ic2,
  input  logic [OCT_W-1:0]  tx_mon1,
  input  logic [CI1_W-1:0]  tx_ci1,
  input  logic              tx_mr1,
  input  logic              tx_mx1,
  input  logic [SUB2_W-1:0] tx_sub2,
  output logic [OCT_W-1:0]  rx_b1,
  output logic [OCT_W-1:0]  rx_b2,
  output logic [OCT_W-1:0]  rx_mon0,
  output logic [SIG_W-1:0]  rx_d,
  output logic [CI0_W-1:0]  rx_ci0,
  output logic              rx_mr0,
  output logic              rx_mx0,
  output logic [OCT_W-1:0]  rx_ic1,
  output logic [OCT_W-1:0]  rx_ic2,
  output logic [OCT_W-1:0]  rx_mon1,
  output logic [CI1_W-1:0]  rx_ci1,
  output logic              rx_mr1,
  output logic              rx_mx1,
  output logic [SUB2_W-1:0] rx_sub2,
  output logic              rx_valid,
  output logic              frame_err
);

  logic [POS_W-1:0] cur_pos;
  logic [POS_W-1:0] next_pos_q;
  chan_t            tx_ch;
  chan_t            rx_ch;

  always_comb begin
    tx_ch      = '0;
    tx_ch.b1   = tx_b1;
    tx_ch.b2   = tx_b2;
    tx_ch.mon0 = tx_mon0;
    tx_ch.sig  = tx_d;
    tx_ch.ci0  = tx_ci0;
    tx_ch.mr0  = tx_mr0;
    tx_ch.mx0  = tx_mx0;
    tx_ch.ic1  = tx_ic1;
    tx_ch.ic2  = tx_ic2;
    tx_ch.mon1 = tx_mon1;
    tx_ch.ci1  = tx_ci1;
    tx_ch.mr1  = tx_mr1;
    tx_ch.mx1  = tx_mx1;
    tx_ch.sub2 = tx_sub2;
  end

  iom_pos_counter u_pos (
    .sclk       (sclk),
    .rst_n      (rst_n),
    .fsync      (fsync),
    .cur_pos    (cur_pos),
    .next_pos_q (next_pos_q),
    .frame_err  (frame_err)
  );

  iom_rx_deframer u_rx (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .sdin     (sdin),
    .cur_pos  (cur_pos),
    .rx_ch    (rx_ch),
    .rx_valid (rx_valid)
  );

  iom_tx_framer u_tx (
    .sclk       (sclk),
    .rst_n      (rst_n),
    .next_pos_q (next_pos_q),
    .tx_ch      (tx_ch),
    .sdout      (sdout)
  );

  always_comb begin
    rx_b1   = rx_ch.b1;
    rx_b2   = rx_ch.b2;
    rx_mon0 = rx_ch.mon0;
    rx_d    = rx_ch.sig;
    rx_ci0  = rx_ch.ci0;
    rx_mr0  = rx_ch.mr0;
    rx_mx0  = rx_ch.mx0;
    rx_ic1  = rx_ch.ic1;
    rx_ic2  = rx_ch.ic2;
    rx_mon1 = rx_ch.mon1;
    rx_ci1  = rx_ch.ci1;
    rx_mr1  = rx_ch.mr1;
    rx_mx1  = rx_ch.mx1;
    rx_sub2 = rx_ch.sub2;
  end

endmodule

// File: rtl/iom_frame_xcvr_chk.sv
module iom_frame_xcvr_chk
  import iom_xcvr_pkg::*;
(
  input logic              sclk,
  input logic              rst_n,
  input logic              fsync,
  input logic              sdout,
  input logic [OCT_W-1:0]  rx_b1,
  input logic [CI1_W-1:0]  rx_ci1,
  input logic [SUB2_W-1:0] rx_sub2,
  input logic              rx_valid,
  input logic              frame_err
);

  // Independent expected-position tracker for the checks below.
  logic [POS_W-1:0] exp_next;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)                    exp_next <= '0;
    else if (fsync)                exp_next <= POS_W'(1);
    else if (exp_next == LAST_POS) exp_next <= '0;
    else                           exp_next <= exp_next + 1'b1;
  end

  // R6
  rx_strobe_single_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6
  rx_strobe_frame_end_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    rx_valid |-> (exp_next == '0));

  // R6
  rx_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_b1) && $stable(rx_ci1) && $stable(rx_sub2)));

  // R7
  err_sticky_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    frame_err |=> frame_err);

  // R7
  err_on_slip_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (fsync && (exp_next != '0)) |=> frame_err);

  // R7
  err_no_cause_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (!frame_err && !(fsync && (exp_next != '0))) |=> !frame_err);

  // R8
  always @(posedge sclk) begin
    if (!rst_n) begin
      reset_state_chk: assert (!rx_valid && !frame_err && !sdout && rx_b1 == '0 && rx_sub2 == '0);
    end
  end

endmodule

bind iom_frame_xcvr iom_frame_xcvr_chk u_chk (
  .sclk      (sclk),
  .rst_n     (rst_n),
  .fsync     (fsync),
  .sdout     (sdout),
  .rx_b1     (rx_b1),
  .rx_ci1    (rx_ci1),
  .rx_sub2   (rx_sub2),
  .rx_valid  (rx_valid),
  .frame_err (frame_err)
);

// File: tb/iom_frame_xcvr_bench.sv
module iom_frame_xcvr_bench;

  logic sclk = 1'b0;
  logic rst_n, fsync, sdin_drv, loop_en;
  wire  sdin;
  logic sdout;
  logic [7:0]  tx_b1, tx_b2, tx_mon0, tx_ic1, tx_ic2, tx_mon1;
  logic [1:0]  tx_d;
  logic [3:0]  tx_ci0;
  logic [5:0]  tx_ci1;
  logic        tx_mr0, tx_mx0, tx_mr1, tx_mx1;
  logic [31:0] tx_sub2;
  logic [7:0]  rx_b1, rx_b2, rx_mon0, rx_ic1, rx_ic2, rx_mon1;
  logic [1:0]  rx_d;
  logic [3:0]  rx_ci0;
  logic [5:0]  rx_ci1;
  logic        rx_mr0, rx_mx0, rx_mr1, rx_mx1;
  logic [31:0] rx_sub2;
  logic        rx_valid, frame_err;

  int checks = 0;
  int fails  = 0;

  assign sdin = loop_en ? sdout : sdin_drv;

  always #10 sclk = ~sclk;

  iom_frame_xcvr u_iom_frame_xcvr (
    .sclk(sclk), .rst_n(rst_n), .fsync(fsync), .sdin(sdin), .sdout(sdout),
    .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_mon0(tx_mon0), .tx_d(tx_d),
    .tx_ci0(tx_ci0), .tx_mr0(tx_mr0), .tx_mx0(tx_mx0),
    .tx_ic1(tx_ic1), .tx_ic2(tx_ic2), .tx_mon1(tx_mon1), .tx_ci1(tx_ci1),
    .tx_mr1(tx_mr1), .tx_mx1(tx_mx1), .tx_sub2(tx_sub2),
    .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_mon0(rx_mon0), .rx_d(rx_d),
    .rx_ci0(rx_ci0), .rx_mr0(rx_mr0), .rx_mx0(rx_mx0),
    .rx_ic1(rx_ic1), .rx_ic2(rx_ic2), .rx_mon1(rx_mon1), .rx_ci1(rx_ci1),
    .rx_mr1(rx_mr1), .rx_mx1(rx_mx1), .rx_sub2(rx_sub2),
    .rx_valid(rx_valid), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   m_next  = 0;
  bit   m_err   = 0;
  bit   m_valid = 0;
  bit   m_sd    = 0;
  bit   rxq[$];
  bit   shq[$];
  bit   wire_cap[96];
  logic [7:0]  e_b1, e_b2, e_mon0, e_ic1, e_ic2, e_mon1;
  logic [1:0]  e_d;
  logic [3:0]  e_ci0;
  logic [5:0]  e_ci1;
  logic        e_mr0, e_mx0, e_mr1, e_mx1;
  logic [31:0] e_sub2;

  function automatic logic [31:0] take(int s, int w);
    logic [31:0] v = '0;
    for (int i = 0; i < w; i++) v = {v[30:0], rxq[s+i]};
    return v;
  endfunction

  task automatic put(input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) shq.push_back(v[i]);
  endtask

  task automatic clear_expect();
    {e_b1, e_b2, e_mon0, e_d, e_ci0, e_mr0, e_mx0} = '0;
    {e_ic1, e_ic2, e_mon1, e_ci1, e_mr1, e_mx1, e_sub2} = '0;
  endtask

  initial clear_expect();

  always @(posedge sclk) begin
    int pos;
    if (!rst_n) begin
      m_next = 0; m_err = 0; m_valid = 0;
      rxq.delete();
      clear_expect();
    end else begin
      pos = fsync ? 0 : m_next;
      if (fsync && m_next != 0) m_err = 1;
      if (pos == 0) rxq.delete();
      rxq.push_back(sdin);
      wire_cap[pos] = sdout;
      m_valid = (pos == 95);
      if (pos == 95 && rxq.size() == 96) begin
        e_b1 = take(0, 8);  e_b2 = take(8, 8);  e_mon0 = take(16, 8);
        e_d  = {rxq[25], rxq[24]};
        e_ci0 = take(26, 4); e_mr0 = rxq[30]; e_mx0 = rxq[31];
        e_ic1 = take(32, 8); e_ic2 = take(40, 8); e_mon1 = take(48, 8);
        e_ci1 = take(56, 6); e_mr1 = rxq[62]; e_mx1 = rxq[63];
        e_sub2 = take(64, 32);
      end
      m_next = (pos + 1) % 96;
    end
  end

  always @(negedge sclk) begin
    if (!rst_n) begin
      m_sd = 0;
    end else begin
      if (m_next == 0) begin
        shq.delete();
        put(tx_b1, 8); put(tx_b2, 8); put(tx_mon0, 8);
        shq.push_back(tx_d[0]); shq.push_back(tx_d[1]);
        put(tx_ci0, 4); shq.push_back(tx_mr0); shq.push_back(tx_mx0);
        put(tx_ic1, 8); put(tx_ic2, 8); put(tx_mon1, 8);
        put(tx_ci1, 6); shq.push_back(tx_mr1); shq.push_back(tx_mx1);
        put(tx_sub2, 32);
      end
      if (shq.size() == 96) m_sd = shq[m_next];
    end
  end

  // Per-cycle comparison, midway between falling and rising edges.
  always @(negedge sclk) begin
    #5;
    if (rst_n) begin
      chk(sdout == m_sd, "R4 sdout bit", 96'(sdout), 96'(m_sd));
      chk(frame_err == m_err, "R7 frame_err", 96'(frame_err), 96'(m_err));
      chk(rx_valid == m_valid, "R6 rx_valid", 96'(rx_valid), 96'(m_valid));
      chk({rx_b1, rx_b2, rx_mon0, rx_d, rx_ci0, rx_mr0, rx_mx0,
           rx_ic1, rx_ic2, rx_mon1, rx_ci1, rx_mr1, rx_mx1, rx_sub2} ==
          {e_b1, e_b2, e_mon0, e_d, e_ci0, e_mr0, e_mx0,
           e_ic1, e_ic2, e_mon1, e_ci1, e_mr1, e_mx1, e_sub2},
          "R2 rx fields",
          {rx_b1, rx_b2, rx_mon0, rx_d, rx_ci0, rx_mr0, rx_mx0,
           rx_ic1, rx_ic2, rx_mon1, rx_ci1, rx_mr1, rx_mx1, rx_sub2},
          {e_b1, e_b2, e_mon0, e_d, e_ci0, e_mr0, e_mx0,
           e_ic1, e_ic2, e_mon1, e_ci1, e_mr1, e_mx1, e_sub2});
    end
  end

  // ---------------- stimulus ----------------
  task automatic scramble_tx();
    {tx_b1, tx_b2, tx_mon0, tx_ic1} = $urandom;
    {tx_ic2, tx_mon1, tx_d, tx_ci0, tx_ci1, tx_mr0, tx_mx0, tx_mr1, tx_mx1} = $urandom;
    tx_sub2 = $urandom;
  endtask

  // Drive one bit's inputs, then let the rising edge take them.
  task automatic bit_step(input bit sync);
    fsync    = sync;
    sdin_drv = $urandom;
    @(posedge sclk);
    #5;
  endtask

  task automatic run_frame(input bit with_sync, input int change_at);
    for (int p = 0; p < 96; p++) begin
      if (p == change_at) scramble_tx();
      bit_step(with_sync && p == 0);
    end
    fsync = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge sclk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] old_b1;
    logic [7:0] b1_on_wire;
    rst_n = 1'b1; fsync = 1'b0; sdin_drv = 1'b0; loop_en = 1'b0;
    tx_b1 = '0; tx_b2 = '0; tx_mon0 = '0; tx_d = '0; tx_ci0 = '0;
    tx_mr0 = 1'b0; tx_mx0 = 1'b0; tx_ic1 = '0; tx_ic2 = '0; tx_mon1 = '0;
    tx_ci1 = '0; tx_mr1 = 1'b0; tx_mx1 = 1'b0; tx_sub2 = '0;
    #1 rst_n = 1'b0;
    scramble_tx();
    sdin_drv = 1'b1;
    repeat (3) @(posedge sclk);
    #5;
    // R8 outputs in reset
    chk(sdout == 1'b0 && rx_valid == 1'b0 && frame_err == 1'b0,
        "R8 reset outputs", 96'({sdout, rx_valid, frame_err}), 96'(0));
    chk(rx_b1 == '0 && rx_sub2 == '0 && rx_ci1 == '0,
        "R8 reset rx fields", 96'({rx_b1, rx_ci1, rx_sub2}), 96'(0));
    rst_n = 1'b1;

    // R1 R2 R4: aligned frames with random traffic
    for (int f = 0; f < 3; f++) begin
      scramble_tx();
      run_frame(1'b1, -1);
      chk(rx_valid == 1'b1, "R6 strobe after frame", 96'(rx_valid), 96'(1));
    end

    // R1: frames run on without sync and still wrap
    for (int f = 0; f < 2; f++) begin
      run_frame(1'b0, -1);
      chk(rx_valid == 1'b1, "R1 wrap without sync", 96'(rx_valid), 96'(1));
    end
    chk(frame_err == 1'b0, "R7 no error when aligned", 96'(frame_err), 96'(0));

    // R5: transmit inputs change mid-frame
    scramble_tx();
    old_b1 = tx_b1;
    run_frame(1'b1, 40);
    b1_on_wire = '0;
    for (int i = 0; i < 8; i++) b1_on_wire = {b1_on_wire[6:0], wire_cap[i]};
    chk(b1_on_wire == old_b1, "R5 frame keeps start-of-frame value",
        96'(b1_on_wire), 96'(old_b1));
    run_frame(1'b1, -1);
    b1_on_wire = '0;
    for (int i = 0; i < 8; i++) b1_on_wire = {b1_on_wire[6:0], wire_cap[i]};
    chk(b1_on_wire == tx_b1, "R5 next frame carries update",
        96'(b1_on_wire), 96'(tx_b1));

    // R7: sync arrives at position 50
    for (int p = 0; p < 50; p++) bit_step(p == 0);
    chk(frame_err == 1'b0, "R7 before slip", 96'(frame_err), 96'(0));
    run_frame(1'b1, -1);
    chk(frame_err == 1'b1, "R7 slip flagged", 96'(frame_err), 96'(1));
    chk(rx_valid == 1'b1, "R7 realigned frame completes", 96'(rx_valid), 96'(1));
    run_frame(1'b1, -1);
    chk(frame_err == 1'b1, "R7 flag stays set", 96'(frame_err), 96'(1));

    // R2 R3 R9: loopback with known values
    loop_en = 1'b1;
    tx_b1 = 8'hA5; tx_b2 = 8'h3C; tx_mon0 = 8'h81; tx_d = 2'b01;
    tx_ci0 = 4'h9; tx_mr0 = 1'b1; tx_mx0 = 1'b0;
    tx_ic1 = 8'h5A; tx_ic2 = 8'hC3; tx_mon1 = 8'h7E; tx_ci1 = 6'h2D;
    tx_mr1 = 1'b0; tx_mx1 = 1'b1; tx_sub2 = 32'hDEAD_BEEF;
    run_frame(1'b1, -1);
    chk(rx_b1 == 8'hA5 && rx_ic2 == 8'hC3 && rx_ci0 == 4'h9 && rx_ci1 == 6'h2D,
        "R2 loopback fields", 96'({rx_b1, rx_ic2, rx_ci0, rx_ci1}),
        96'({8'hA5, 8'hC3, 4'h9, 6'h2D}));
    chk(wire_cap[24] == 1'b1 && wire_cap[25] == 1'b0, "R3 signalling bit 0 first",
        96'({wire_cap[24], wire_cap[25]}), 96'(2'b10));
    chk(rx_d == 2'b01, "R3 signalling received", 96'(rx_d), 96'(2'b01));
    chk(rx_sub2 == 32'hDEAD_BEEF, "R9 third subframe", 96'(rx_sub2), 96'(32'hDEAD_BEEF));
    tx_d = 2'b10; tx_sub2 = 32'h0123_4567;
    run_frame(1'b1, -1);
    chk(rx_d == 2'b10 && rx_sub2 == 32'h0123_4567, "R9 second loopback",
        96'({rx_d, rx_sub2}), 96'({2'b10, 32'h0123_4567}));
    loop_en = 1'b0;

    repeat (3) bit_step(1'b0);
    finish_run();
  end

endmodule